// File: doc/BRIEF.md
# Rational Clock Enable Scaler

This block thins a stream of clock-enable pulses into a slower enable stream in the same clock domain. A two-bit mode picks the kind of scaling: straight pass-through, a 1/N divider whose N may carry a half step, a rational reducer that keeps m+1 of every n+1 input pulses, or a sixteen-slot swallower that keeps m+1 of every 16. The output is an enable for downstream logic, never a derived clock.

Mode and coefficients are captured only on a configuration strobe, which also clears every counter and accumulator. Between strobes the mode and coefficient inputs may change freely without effect. In the rational and swallower modes the kept pulses are spread evenly through the window by an error accumulator, not grouped at its start.

Top module: `rate_enable_scaler`

## Requirements
- R1: After reset the block behaves as pass-through (out_en_o equals in_en_i) with all scaler state cleared, until the first strobe.
- R2: Mode 0 (pass) asserts out_en_o on every cycle with in_en_i high and cfg_stb_i low; the m and n values are ignored.
- R3: Mode 1 (divider) reads n as an integer part q = n[W-1:1] and a half-step bit n[0]. With n[0]=0 and q>=1 one output is given per q input pulses, the first on the q-th pulse after the strobe. With q=0 every pulse passes and the half-step bit is ignored.
- R4: Mode 1 with n[0]=1 and q>=1 alternates output periods of q and q+1 input pulses, starting with q, so the mean period is q+0.5.
- R5: Mode 2 (rational) with m<n treats m and n as integers, sets k=m+1 and d=n+1, and keeps input pulse j (counted from 1 after the strobe) exactly when floor(j*k/d) > floor((j-1)*k/d).
- R6: Mode 2 with m>=n passes every input pulse.
- R7: Mode 3 (swallower) with m<15 keeps pulse j exactly when floor(j*(m+1)/16) > floor((j-1)*(m+1)/16).
- R8: Mode 3 with m>=15 passes every input pulse.
- R9: A cycle with cfg_stb_i high loads mode, m and n, forces out_en_o low that cycle and clears all counters; mode, m and n have no effect on any other cycle.
- R10: out_en_o is never high on a cycle where in_en_i is low.
- R11: Cycles with in_en_i low do not advance any scaler state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_en_i | input | 1 | Input enable pulse stream |
| mode_i | input | 2 | Scaler kind: 0 pass, 1 divider, 2 rational, 3 swallower |
| m_i | input | W | Numerator coefficient (integer) |
| n_i | input | W | Denominator coefficient; in mode 1 the low bit is a half step |
| cfg_stb_i | input | 1 | Loads mode, m, n and clears scaler state |
| out_en_o | output | 1 | Scaled enable, same cycle as the input pulse it keeps |

## Verification
The keep decision for an input pulse appears on out_en_o combinationally in the same cycle as that pulse, from state updated at the previous edge; a strobe takes effect from the cycle after it. The bench drives inputs at the falling edge, compares out_en_o one nanosecond later against a bench model stepped with the same inputs, and only then advances the model, so each check lines up with the edge the design will use. Window counts over long runs of pulses confirm the average ratios independently of the per-cycle model.

// File: rtl/res_pkg.sv
package res_pkg;
  typedef enum logic [1:0] {
    SCL_PASS = 2'd0,
    SCL_HALF = 2'd1,
    SCL_RAT  = 2'd2,
    SCL_SWL  = 2'd3
  } scl_mode_e;

  localparam int unsigned SWL_SLOTS = 16;
endpackage

// File: rtl/res_cfg.sv
module res_cfg #(
  parameter int unsigned W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic [1:0]         mode_i,
  input  logic [W-1:0]       m_i,
  input  logic [W-1:0]       n_i,
  output res_pkg::scl_mode_e mode_o,
  output logic [W-1:0]       m_o,
  output logic [W-1:0]       n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= res_pkg::SCL_PASS;
      m_o    <= '0;
      n_o    <= '0;
    end else if (stb_i) begin
      mode_o <= res_pkg::scl_mode_e'(mode_i);
      m_o    <= m_i;
      n_o    <= n_i;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> ($stable(m_o) && $stable(n_o) && $stable(mode_o)));
endmodule

// File: rtl/res_half_div.sv
module res_half_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] n_i,
  output logic         hit_o
);
  localparam int unsigned QW = W - 1;

  logic [QW-1:0] q, cnt_q;
  logic          ph_q;
  logic [W-1:0]  tgt;

  assign q     = n_i[W-1:1];
  // long period on odd phase only when the half step is set
  assign tgt   = {1'b0, q} + W'(n_i[0] & ph_q);
  assign hit_o = (q == '0) || ({1'b0, cnt_q} == tgt - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (step_i && q != '0) begin
      if (hit_o) begin
        cnt_q <= '0;
        ph_q  <= ph_q ^ n_i[0];
      end else begin
        cnt_q <= cnt_q + QW'(1);
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q != '0) |-> ({1'b0, cnt_q} < tgt));

  // R11
  div_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> ($stable(cnt_q) && $stable(ph_q)));
endmodule

// File: rtl/res_acc.sv
module res_acc #(
  parameter int unsigned W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       step_i,
  input  logic [W:0] num_i,
  input  logic [W:0] den_i,
  output logic       hit_o
);
  logic [W:0]   acc_q;
  logic [W+1:0] sum;

  assign sum   = {1'b0, acc_q} + {1'b0, num_i};
  assign hit_o = (sum >= {1'b0, den_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= hit_o ? W'(sum - {1'b0, den_i}) + (W+1)'(0) : sum[W:0];
  end

  // R5
  acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_i < den_i && !$past(step_i)) |-> (acc_q < den_i));

  // R11
  acc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/rate_enable_scaler.sv
module rate_enable_scaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_en_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] n_i,
  input  logic         cfg_stb_i,
  output logic         out_en_o
);
  import res_pkg::*;

  localparam logic [W:0] SWL_DEN = (W+1)'(SWL_SLOTS);
  localparam logic [W-1:0] SWL_FULL = W'(SWL_SLOTS - 1);

  scl_mode_e  mode_q;
  logic [W-1:0] m_q, n_q;
  logic       live, rat_pass, swl_pass, acc_on;
  logic       div_hit, acc_hit, keep;
  logic [W:0] num, den;

  res_cfg #(.W(W)) cfg_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(cfg_stb_i),
    .mode_i(mode_i), .m_i(m_i), .n_i(n_i),
    .mode_o(mode_q), .m_o(m_q), .n_o(n_q)
  );

  assign live     = in_en_i & ~cfg_stb_i;
  assign rat_pass = (m_q >= n_q);
  assign swl_pass = (m_q >= SWL_FULL);
  assign acc_on   = (mode_q == SCL_RAT && !rat_pass) || (mode_q == SCL_SWL && !swl_pass);
  assign num      = {1'b0, m_q} + (W+1)'(1);
  assign den      = (mode_q == SCL_RAT) ? ({1'b0, n_q} + (W+1)'(1)) : SWL_DEN;

  res_half_div #(.W(W)) div_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cfg_stb_i),
    .step_i(live && mode_q == SCL_HALF), .n_i(n_q), .hit_o(div_hit)
  );

  // one accumulator serves both the rational and the swallower modes
  res_acc #(.W(W)) acc_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cfg_stb_i),
    .step_i(live && acc_on), .num_i(num), .den_i(den), .hit_o(acc_hit)
  );

  always_comb begin
    unique case (mode_q)
      SCL_PASS: keep = 1'b1;
      SCL_HALF: keep = div_hit;
      SCL_RAT:  keep = rat_pass | acc_hit;
      SCL_SWL:  keep = swl_pass | acc_hit;
      default:  keep = 1'b1;
    endcase
  end

  assign out_en_o = live & keep;

  // R10
  out_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> in_en_i);

  // R9
  stb_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_stb_i |-> !out_en_o);

  // R2
  pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == SCL_PASS && live) |-> out_en_o);
endmodule

// File: tb/rate_enable_scaler_tb_top.sv
module rate_enable_scaler_tb_top;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_en = 1'b0, stb = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [W-1:0] m = '0, n = '0;
  logic out_en;

  int errors = 0, checks = 0, outs = 0;
  bit done = 1'b0;

  // bench model state
  int md_m = 0, m_m = 0, n_m = 0, cnt_m = 0, ph_m = 0, acc_m = 0;

  always #2 clk = ~clk;

  rate_enable_scaler #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_en_i(in_en), .mode_i(mode),
    .m_i(m), .n_i(n), .cfg_stb_i(stb), .out_en_o(out_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected output for current inputs, then advance the model
  task automatic model(output int e, output string tag);
    int q, h, tgt, k, d, s;
    e = 0;
    if (stb) begin
      tag = "R9";
      md_m = int'(mode); m_m = int'(m); n_m = int'(n);
      cnt_m = 0; ph_m = 0; acc_m = 0;
      return;
    end
    if (!in_en) begin tag = "R11"; return; end
    case (md_m)
      0: begin tag = "R2"; e = 1; end
      1: begin
        q = n_m / 2; h = n_m % 2;
        tag = h ? "R4" : "R3";
        if (q == 0) begin e = 1; tag = "R3"; end
        else begin
          tgt = q + (h & ph_m);
          if (cnt_m == tgt - 1) begin e = 1; cnt_m = 0; ph_m ^= h; end
          else cnt_m++;
        end
      end
      default: begin
        k = m_m + 1;
        d = (md_m == 2) ? n_m + 1 : 16;
        if ((md_m == 2 && m_m >= n_m) || (md_m == 3 && m_m >= 15)) begin
          e = 1; tag = (md_m == 2) ? "R6" : "R8";
        end else begin
          tag = (md_m == 2) ? "R5" : "R7";
          s = acc_m + k;
          if (s >= d) begin e = 1; acc_m = s - d; end
          else acc_m = s;
        end
      end
    endcase
  endtask

  task automatic cyc(input bit ie, input bit st, input int md, input int mm, input int nn);
    int e;
    string tag;
    @(negedge clk);
    in_en = ie; stb = st; mode = 2'(md); m = W'(mm); n = W'(nn);
    #1;
    model(e, tag);
    chk(tag, int'(out_en), e);
    if (out_en && !in_en) chk("R10", 1, 0);
    if (out_en) outs++;
  endtask

  task automatic cfg(input int md, input int mm, input int nn);
    cyc(1'b1, 1'b1, md, mm, nn);
  endtask

  // random noise on mode/m/n with no strobe
  task automatic run(input int len, input int dens);
    for (int i = 0; i < len; i++)
      cyc(($urandom % 100) < dens, 1'b0, $urandom % 4, $urandom % 256, $urandom % 256);
  endtask

  task automatic window(input int len, input int exp, input string req);
    outs = 0;
    run(len, 100);
    chk(req, outs, exp);
  endtask

  initial begin
    void'($urandom(32'h5ca1e));
    @(negedge clk); in_en = 1'b1; #1;
    chk("R1", int'(out_en), 1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1; chk("R1", int'(out_en), 1);
    run(20, 60);

    cfg(0, 9, 3);   run(30, 50);
    cfg(1, 0, 6);   window(30, 10, "R3");
    cfg(1, 0, 7);   window(35, 10, "R4");
    cfg(1, 0, 1);   window(12, 12, "R3");
    cfg(2, 2, 4);   window(50, 30, "R5");
    cfg(2, 2, 4);   run(60, 40);
    cfg(2, 5, 3);   window(20, 20, "R6");
    cfg(3, 4, 0);   window(32, 10, "R7");
    cfg(3, 0, 0);   window(48, 3, "R7");
    cfg(3, 15, 0);  window(16, 16, "R8");
    cfg(3, 200, 0); window(16, 16, "R8");
    cfg(1, 0, 255); run(400, 70);

    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 100) < 3)
        cyc($urandom % 2, 1'b1, $urandom % 4, $urandom % 256, $urandom % 256);
      else
        cyc(($urandom % 100) < 70, 1'b0, $urandom % 4, $urandom % 256, $urandom % 256);
    end
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 100) < 2)
        cyc(1'b1, 1'b1, 2 + $urandom % 2, $urandom % 24, $urandom % 24);
      else
        cyc(($urandom % 100) < 80, 1'b0, $urandom % 4, $urandom % 256, $urandom % 256);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule